// File: doc/BRIEF.md
# CPU Clock Mode Controller

This block chooses which clock source feeds the CPU and how far that source is divided. There are four sources: the main oscillator, a low-frequency sub oscillator, an on-chip ring oscillator and a PLL. Each source is represented by a single-cycle tick strobe that is synchronous to the block clock. Software writes one 12-bit control word. The block checks each write against a set of ordering and availability rules. It commits a legal write whole and refuses an illegal one whole. A refused write leaves the stored word unchanged, pulses a reject flag and sets a sticky error flag.

From the stored word the block derives a mode code and the active source. It also produces `cpu_en_o`, a one-cycle enable that marks each CPU clock edge at the selected rate. When a write moves the CPU to a different source, the enable is held low until a programmable number of ticks from the new source have arrived. Certain bits are pinned to 1 while the main oscillator is stopped.

Top module: `clkmode_ctrl`

## Requirements
- R1: After reset the stored word is 0x004 (only the divide-by-8 bit, bit 2, set), the mode code is 1 (divided main clock), the error flag is 0 and `cpu_en_o` stays low until a tick arrives.
- R2: For the main and ring sources the ratio is 8 when bit 2 is 1. Otherwise the field in bits 5:4 sets it: 00 gives 1, 01 gives 2, 10 gives 4, 11 gives 16. The sub source (bit 3) and the PLL source (bit 10) run at ratio 1. After an accepted write the enable pulses on the tick that completes each group of ratio ticks.
- R3: Only ticks of the active source advance the divider. The active source is PLL if bit 10 is set, else ring if bit 8 is set, else sub if bit 3 is set, else main. A tick on any other line leaves `cpu_en_o` low.
- R4: After an accepted write that changes the active source, the first `settle_lim` ticks of the new source produce no enable.
- R5: A refused write leaves the stored word unchanged. It drives `rej_o` high for the following cycle and sets `err_o`, which stays set until reset.
- R6: While the stop-detect enable (bit 9) is 1, any write that would change a bit other than bit 9 is refused.
- R7: A write that changes bit 2 and bits 5:4 in the same access is refused.
- R8: A write with bit 3 set is refused unless bit 0 (sub oscillator enable) is set both in the stored word and in the written word. Bits 3 and 8 may not both be 1.
- R9: A write that clears bit 8 is refused unless bit 2 is already 1 in the stored word.
- R10: Setting bit 1 (main oscillator stop) is refused unless bit 3 is 1 in both the stored and the written word. While bit 1 is 1 and bit 8 is 0, bits 2 and 6 are stored as 1 whatever was written.
- R11: Bit 10 may be set only when the stored and the written word are both in undivided main mode with bit 7 (PLL reference ready) set. While bit 10 is stored as 1, a write that clears bit 7 is refused.
- R12: While bit 10 is stored as 1, the value written to bit 11 (wait select) is ignored and the old value is kept. The write itself is not refused.
- R13: `mode_o` is 5 for PLL, 4 for ring, 3 for sub with the main oscillator stopped, 2 for sub, 0 for main at ratio 1 and 1 for main divided.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 12 | Control word to write |
| settle_lim | input | SET_W | New-source ticks to wait after a source switch |
| tick_main | input | 1 | Main oscillator tick |
| tick_sub | input | 1 | Sub oscillator tick |
| tick_ring | input | 1 | Ring oscillator tick |
| tick_pll | input | 1 | PLL tick |
| cfg_o | output | 12 | Stored control word |
| mode_o | output | 3 | Current mode code |
| cpu_en_o | output | 1 | CPU clock enable pulse |
| rej_o | output | 1 | Last write was refused |
| err_o | output | 1 | Sticky refusal flag |

## Verification
The divider is run on the main source at every ratio, on the ring source at ratio 1 and at ratio 4, and on the sub and PLL sources at ratio 1. This shows whether the divide field, the divide-by-8 override and the per-source bypass each select the correct pulse spacing. Every source switch is followed by a tick run that counts the settle delay, and a tick on an inactive line is checked to show that the tick mux ignores it. Each guard rule gets a write that breaks it, with the stored word and the reject flag checked afterwards. A nearby legal write is then accepted, which separates an over-strict guard from a correct one.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

  localparam int CFG_W   = 12;
  localparam int MAX_DIV = 16;
  localparam int CNT_W   = $clog2(MAX_DIV);

  typedef struct packed {
    logic       wait1;     // 11
    logic       pll_on;    // 10
    logic       osd_en;    // 9
    logic       ring_sel;  // 8
    logic       ref_ok;    // 7
    logic       drive_hi;  // 6
    logic [1:0] div_fld;   // 5:4
    logic       sub_sel;   // 3
    logic       div8;      // 2
    logic       main_stop; // 1
    logic       sub_en;    // 0
  } cfg_t;

  localparam logic [CFG_W-1:0] CFG_RST  = 12'h004;
  localparam logic [CFG_W-1:0] OSD_BIT  = 12'h200;

  typedef enum logic [2:0] {
    MODE_HIGH   = 3'd0,
    MODE_MID    = 3'd1,
    MODE_LOW    = 3'd2,
    MODE_LOWPWR = 3'd3,
    MODE_RING   = 3'd4,
    MODE_PLL    = 3'd5
  } mode_e;

  typedef enum logic [1:0] {
    SRC_MAIN = 2'd0,
    SRC_SUB  = 2'd1,
    SRC_RING = 2'd2,
    SRC_PLL  = 2'd3
  } src_e;

  function automatic src_e src_of(cfg_t c);
    if (c.pll_on)   return SRC_PLL;
    if (c.ring_sel) return SRC_RING;
    if (c.sub_sel)  return SRC_SUB;
    return SRC_MAIN;
  endfunction

  function automatic mode_e mode_of(cfg_t c);
    if (c.pll_on)   return MODE_PLL;
    if (c.ring_sel) return MODE_RING;
    if (c.sub_sel)  return c.main_stop ? MODE_LOWPWR : MODE_LOW;
    if (c.div8 || (c.div_fld != 2'b00)) return MODE_MID;
    return MODE_HIGH;
  endfunction

  // terminal count (ratio - 1) of the divider
  function automatic logic [CNT_W-1:0] last_of(cfg_t c);
    src_e s;
    s = src_of(c);
    if ((s == SRC_SUB) || (s == SRC_PLL)) return '0;
    if (c.div8) return CNT_W'(7);
    case (c.div_fld)
      2'b00:   return CNT_W'(0);
      2'b01:   return CNT_W'(1);
      2'b10:   return CNT_W'(3);
      default: return CNT_W'(MAX_DIV - 1);
    endcase
  endfunction

endpackage

// File: rtl/clkmode_rstsync.sv
module clkmode_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/clkmode_guard.sv
module clkmode_guard
  import clkmode_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  cfg_t wr_data,
  output cfg_t cfg_q,
  output logic accept_o,
  output logic switch_o,
  output logic rej_q,
  output logic err_q
);
  cfg_t w, c, nxt;
  logic ok;

  always_comb begin
    w  = wr_data;
    c  = cfg_q;
    ok = 1'b1;
    // stop-detect lock: only bit 9 may move
    if (c.osd_en && (((w ^ c) & ~OSD_BIT) != '0)) ok = 1'b0;
    // divide field must settle before the /8 bit moves
    if ((w.div8 != c.div8) && (w.div_fld != c.div_fld)) ok = 1'b0;
    // sub clock selectable only while it runs
    if (w.sub_sel && !(c.sub_en && w.sub_en)) ok = 1'b0;
    if (w.sub_sel && w.ring_sel) ok = 1'b0;
    // leaving ring mode only from /8
    if (c.ring_sel && !w.ring_sel && !c.div8) ok = 1'b0;
    // main stop only from sub clock mode
    if (w.main_stop && !w.sub_sel) ok = 1'b0;
    if (w.main_stop && !c.main_stop && !c.sub_sel) ok = 1'b0;
    // PLL entry and exit ordering
    if (w.pll_on) begin
      if (w.sub_sel || w.ring_sel || w.div8 || (w.div_fld != 2'b00) || !w.ref_ok)
        ok = 1'b0;
      if (!c.pll_on &&
          (c.sub_sel || c.ring_sel || c.div8 || (c.div_fld != 2'b00) || !c.ref_ok))
        ok = 1'b0;
    end
    if (c.pll_on && !w.ref_ok) ok = 1'b0;

    nxt = w;
    if (c.pll_on) nxt.wait1 = c.wait1;
    if (nxt.main_stop && !nxt.ring_sel) begin
      nxt.div8     = 1'b1;
      nxt.drive_hi = 1'b1;
    end
  end

  assign accept_o = wr_en & ok;
  assign switch_o = accept_o & (src_of(nxt) != src_of(cfg_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST;
      rej_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      rej_q <= wr_en & ~ok;
      if (wr_en & ~ok) err_q <= 1'b1;
      if (accept_o)    cfg_q <= nxt;
    end
  end
endmodule

// File: rtl/clkmode_settle.sv
module clkmode_settle #(
  parameter int SET_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SET_W-1:0] limit,
  input  logic             tick,
  output logic             busy
);
  logic [SET_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                       cnt_d = limit;
    else if (tick && (cnt_q != '0)) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/clkmode_divider.sv
module clkmode_divider #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             hold,
  input  logic             tick,
  input  logic [CNT_W-1:0] last,
  output logic             en
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign en = tick & ~hold & (cnt_q == last);

  always_comb begin
    cnt_d = cnt_q;
    if (restart || hold) cnt_d = '0;
    else if (tick)       cnt_d = en ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
  import clkmode_pkg::*;
#(
  parameter int SET_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [11:0]      wr_data,
  input  logic [SET_W-1:0] settle_lim,
  input  logic             tick_main,
  input  logic             tick_sub,
  input  logic             tick_ring,
  input  logic             tick_pll,
  output logic [11:0]      cfg_o,
  output logic [2:0]       mode_o,
  output logic             cpu_en_o,
  output logic             rej_o,
  output logic             err_o
);
  logic       rst_i_n;
  cfg_t       cfg_q;
  logic       accept, src_switch, settle_busy, tick_sel;
  src_e       src;

  clkmode_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  clkmode_guard u_guard (
    .clk(clk), .rst_n(rst_i_n), .wr_en(wr_en), .wr_data(cfg_t'(wr_data)),
    .cfg_q(cfg_q), .accept_o(accept), .switch_o(src_switch),
    .rej_q(rej_o), .err_q(err_o)
  );

  assign src = src_of(cfg_q);

  always_comb begin
    case (src)
      SRC_SUB:  tick_sel = tick_sub;
      SRC_RING: tick_sel = tick_ring;
      SRC_PLL:  tick_sel = tick_pll;
      default:  tick_sel = tick_main;
    endcase
  end

  clkmode_settle #(.SET_W(SET_W)) u_settle (
    .clk(clk), .rst_n(rst_i_n), .load(src_switch), .limit(settle_lim),
    .tick(tick_sel), .busy(settle_busy)
  );

  clkmode_divider #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_i_n), .restart(accept), .hold(settle_busy),
    .tick(tick_sel), .last(last_of(cfg_q)), .en(cpu_en_o)
  );

  assign cfg_o  = cfg_q;
  assign mode_o = mode_of(cfg_q);
endmodule

// File: rtl/clkmode_ctrl_chk.sv
module clkmode_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] cfg,
  input logic        cpu_en,
  input logic        rej,
  input logic        err,
  input logic        busy,
  input logic        tick_sel
);
  assert_enable_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_en |-> tick_sel);

  assert_settle_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cpu_en);

  assert_reject_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rej |-> (cfg == $past(cfg)));

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err) |-> err);

  assert_osd_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[9] && $past(cfg[9])) |-> ({cfg[11:10], cfg[8:0]} == $past({cfg[11:10], cfg[8:0]})));

  assert_sub_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg[3] |-> cfg[0]);

  assert_stop_forces_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[1] && !cfg[8]) |-> (cfg[2] && cfg[6]));

  assert_pll_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg[10] |-> (!cfg[3] && !cfg[8] && !cfg[2] && (cfg[5:4] == 2'b00) && cfg[7]));

  assert_wait_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg[10]) && cfg[10]) |-> (cfg[11] == $past(cfg[11])));
endmodule

bind clkmode_ctrl clkmode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg(cfg_o), .cpu_en(cpu_en_o), .rej(rej_o),
  .err(err_o), .busy(settle_busy), .tick_sel(tick_sel)
);

// File: tb/clkmode_ctrl_tb.sv
module clkmode_ctrl_tb;
  localparam int SET_W = 8;
  localparam int K_EN = 0, K_CFG = 1, K_MODE = 2, K_REJ = 3, K_ERR = 4;
  localparam int T_MAIN = 0, T_SUB = 1, T_RING = 2, T_PLL = 3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             wr_en;
  logic [11:0]      wr_data;
  logic [SET_W-1:0] settle_lim;
  logic             tick_main, tick_sub, tick_ring, tick_pll;
  logic [11:0]      cfg_o;
  logic [2:0]       mode_o;
  logic             cpu_en_o, rej_o, err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { int kind; int exp; string tag; } item_t;
  item_t sb[$];
  event  chk_ev;

  always #2 clk = ~clk;

  clkmode_ctrl #(.SET_W(SET_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .settle_lim(settle_lim), .tick_main(tick_main), .tick_sub(tick_sub),
    .tick_ring(tick_ring), .tick_pll(tick_pll), .cfg_o(cfg_o),
    .mode_o(mode_o), .cpu_en_o(cpu_en_o), .rej_o(rej_o), .err_o(err_o)
  );

  function automatic int actual(int kind);
    case (kind)
      K_EN:   return int'(cpu_en_o);
      K_CFG:  return int'(cfg_o);
      K_MODE: return int'(mode_o);
      K_REJ:  return int'(rej_o);
      default: return int'(err_o);
    endcase
  endfunction

  task automatic drain();
    while (sb.size() > 0) begin
      item_t it;
      int act;
      it  = sb.pop_front();
      act = actual(it.kind);
      checks++;
      if (act != it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=0x%0h expected=0x%0h", it.tag, it.kind, act, it.exp);
      end
    end
  endtask

  // monitor
  always begin
    @(chk_ev);
    drain();
  end

  task automatic expect_item(int kind, int exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    -> chk_ev;
    #0;
  endtask

  task automatic wr(logic [11:0] data, int exp_cfg, int exp_rej, string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
    expect_item(K_CFG, exp_cfg, tag);
    expect_item(K_REJ, exp_rej, tag);
  endtask

  task automatic set_tick(int which, logic v);
    case (which)
      T_MAIN: tick_main = v;
      T_SUB:  tick_sub  = v;
      T_RING: tick_ring = v;
      default: tick_pll = v;
    endcase
  endtask

  // n ticks from a fresh divider: pulse when i > s and (i - s) is a multiple of r
  task automatic run_ticks(int which, int n, int r, int s, string tag);
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      set_tick(which, 1'b1);
      #1;
      expect_item(K_EN, ((i > s) && (((i - s) % r) == 0)) ? 1 : 0, tag);
    end
    @(negedge clk);
    set_tick(which, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      drain();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; settle_lim = SET_W'(2);
    tick_main = 1'b0; tick_sub = 1'b0; tick_ring = 1'b0; tick_pll = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state, R13 mode code
    expect_item(K_CFG, 'h004, "R1 reset word");
    expect_item(K_MODE, 1, "R1 R13 reset mode");
    expect_item(K_ERR, 0, "R1 reset err");
    expect_item(K_EN, 0, "R1 no enable without tick");

    // R2 main /8 by default
    run_ticks(T_MAIN, 16, 8, 0, "R2 main div8");
    wr('h014, 'h014, 0, "R2 field under div8");
    run_ticks(T_MAIN, 8, 8, 0, "R2 div8 overrides field");

    // R7 both divide controls in one write
    wr('h020, 'h014, 1, "R7 joint change refused");
    expect_item(K_ERR, 1, "R5 err set");

    wr('h010, 'h010, 0, "R2 to div2");
    run_ticks(T_MAIN, 4, 2, 0, "R2 main div2");
    wr('h030, 'h030, 0, "R2 to div16");
    run_ticks(T_MAIN, 16, 16, 0, "R2 main div16");
    wr('h000, 'h000, 0, "R2 to div1");
    expect_item(K_MODE, 0, "R13 high mode");
    run_ticks(T_MAIN, 3, 1, 0, "R2 main div1");
    wr('h020, 'h020, 0, "R2 to div4");
    expect_item(K_MODE, 1, "R13 mid mode");
    run_ticks(T_MAIN, 8, 4, 0, "R2 main div4");
    wr('h000, 'h000, 0, "R2 back to div1");

    // R8 sub clock select
    wr('h008, 'h000, 1, "R8 sub select without enable");
    wr('h001, 'h001, 0, "R8 sub enable");
    wr('h009, 'h009, 0, "R8 sub select");
    expect_item(K_MODE, 2, "R13 low mode");
    run_ticks(T_MAIN, 1, 1, 1, "R3 inactive tick ignored");
    run_ticks(T_SUB, 5, 1, 2, "R4 settle on sub");

    // R10 main stop and forced bits
    wr('h00B, 'h04F, 0, "R10 stop from sub forces bits");
    expect_item(K_MODE, 3, "R13 lowpwr mode");
    wr('h00B, 'h04F, 0, "R10 forced bits hold");
    wr('h049, 'h049, 0, "R10 main restart");
    wr('h041, 'h041, 0, "R3 back to main");
    run_ticks(T_MAIN, 4, 1, 2, "R4 settle on main");
    wr('h043, 'h041, 1, "R10 stop from main refused");

    // R9 ring mode
    wr('h141, 'h141, 0, "R9 enter ring");
    expect_item(K_MODE, 4, "R13 ring mode");
    run_ticks(T_RING, 3, 1, 2, "R4 settle on ring");
    wr('h161, 'h161, 0, "R2 ring div4");
    run_ticks(T_RING, 8, 4, 0, "R2 ring div4 run");
    wr('h061, 'h161, 1, "R9 leave ring without div8");
    wr('h165, 'h165, 0, "R9 set div8 in ring");
    wr('h065, 'h065, 0, "R9 leave ring from div8");
    run_ticks(T_MAIN, 10, 8, 2, "R4 settle then div8");

    // R6 stop-detect lock
    wr('h265, 'h265, 0, "R6 lock on");
    wr('h245, 'h265, 1, "R6 change under lock");
    wr('h065, 'h065, 0, "R6 lock off");

    // R11 PLL
    wr('h045, 'h045, 0, "R11 field to 00");
    wr('h041, 'h041, 0, "R11 to high");
    wr('h4C1, 'h041, 1, "R11 pll without ready");
    wr('h0C1, 'h0C1, 0, "R11 ready");
    wr('h4C1, 'h4C1, 0, "R11 pll on");
    expect_item(K_MODE, 5, "R13 pll mode");
    run_ticks(T_PLL, 3, 1, 2, "R4 settle on pll");
    wr('hCC1, 'h4C1, 0, "R12 wait ignored in pll");
    wr('h041, 'h4C1, 1, "R11 ready cleared first");
    wr('h0C1, 'h0C1, 0, "R11 pll off");
    wr('h8C1, 'h8C1, 0, "R12 wait written with pll off");
    expect_item(K_ERR, 1, "R5 err still set");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule